// File: doc/BRIEF.md
# CCD Sampling Timing Generator

This block derives the sampling strobes for a three-input CCD front end from a master clock and a video-sample sync pulse. Each sync pulse, seen high on a clock rising edge, starts a short sequence counted in clock edges. A video-sample strobe fires on the first edge after the sync edge. A reset-sample strobe fires at a programmable edge, and an optional clamp pulse fires one edge before the reset sample. The strobes are shared by the red, green and blue inputs, which are sampled together. The block also drives the one-hot select of the multiplexer that feeds the single converter, and a 3-bit colour code. The colour code names the channel and which of the two coefficient reads is current, so it can serve directly as low external RAM address bits.

Four operating modes set the expected sync spacing: colour and monochrome (6 clocks), fast monochrome (3 clocks) and max-speed monochrome (2 clocks). The configuration inputs are expected to be static while a sequence runs. In this description, "edge k" is the k-th clock rising edge after the edge that sampled the sync pulse high. Every output is registered, so a strobe "on edge k" is high for the one clock cycle that starts at edge k.

Top module: `tsg_timing_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first sync pulse, the strobes, the clamp, the multiplexer select (000) and the colour code (000) are all low.
- R2: In colour mode (mode 00) the video strobe fires on edge 1. With correlated double sampling enabled and reset-position field 01, the reset strobe fires on edge 4.
- R3: The reset-position field sets the reset strobe in modes 00 and 01 with correlated double sampling: 00 gives edge 3, 01 gives edge 4, 10 gives edge 5 and 11 gives edge 6. The clamp pulse always sits one edge before the reset strobe.
- R4: The clamp pulse is produced only if the clamp request is high on the sync edge. With the default field it fires on edge 3, three clocks after the request was sampled.
- R5: With correlated double sampling disabled, the reset strobe fires on the same edge as the video strobe. The clamp keeps its programmed position.
- R6: In colour mode, edges 1 to 6 give the colour codes 000, 001, 010, 011, 100 and 101 (red 00x, green 01x, blue 10x; bit 0 marks the second coefficient read). The one-hot multiplexer select reads 001 for red, 010 for green and 100 for blue.
- R7: In monochrome mode (01) the multiplexer stays on the channel given by the 2-bit select (00 red, 01 green, 10 blue; the reserved value 11 acts as red). Code bits [2:1] show that channel and bit 0 alternates 0,1 over edges 1 to 6.
- R8: In fast monochrome mode (10) with correlated double sampling, the reset strobe is fixed on edge 2 and the clamp on edge 1, whatever the reset-position field holds. Code bit 0 stays 0.
- R9: In max-speed monochrome mode (11), correlated double sampling is unavailable: the reset strobe fires on edge 1 with the video strobe even if enabled, and the clamp fires on edge 1.
- R10: A sync pulse arriving before the current sequence ends restarts the count. Strobes still pending from the earlier sync do not fire.
- R11: Every strobe is a single-cycle pulse that fires at most once per sync. No strobe fires after edge 6 without a new sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_i | input | 1 | Video-sample sync pulse, sampled on the clock |
| clamp_req_i | input | 1 | Clamp request, sampled on the sync edge |
| mode_i | input | 2 | 00 colour, 01 monochrome, 10 fast monochrome, 11 max-speed monochrome |
| cds_en_i | input | 1 | 1 = correlated double sampling, 0 = single-ended |
| rs_pos_i | input | 2 | Reset-sample position: 00 early, 01 default, 10 late, 11 later |
| mono_sel_i | input | 2 | Monochrome channel: 00 red, 01 green, 10 blue, 11 reserved (red) |
| vs_strb_o | output | 1 | Video-sample strobe |
| rs_strb_o | output | 1 | Reset-sample strobe |
| clamp_o | output | 1 | Clamp pulse |
| mux_sel_o | output | 3 | One-hot converter multiplexer select (bit0 red, bit1 green, bit2 blue) |
| cc_o | output | 3 | Colour code: channel in [2:1], read index in [0] |

## Verification
The hardest situation to reach is a restart: a second sync pulse that lands while strobes from the first are still pending. The outcome depends on the edge index held over from the old sequence and on the count being reloaded in the same clock. The bench reaches it by raising the sync pulse again two edges into a trace, so the second sync is sampled on edge 3. It then records every edge and checks that the reset strobe from the first sync never fires and that the second sequence's timing starts from that edge. The fixed-position modes are checked with a non-default reset-position field, to show that the field has no effect there.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

  typedef enum logic [1:0] {
    MD_COLOUR = 2'b00,
    MD_MONO   = 2'b01,
    MD_FAST   = 2'b10,
    MD_MAX    = 2'b11
  } mode_e;

  // Edge positions counted from the sync edge
  parameter int unsigned VS_EDGE    = 1;
  parameter int unsigned RS_DEFAULT = 4;
  parameter int unsigned CL_LEAD    = 1;
  parameter int unsigned FAST_RS    = 2;
  parameter int unsigned SEQ_LEN    = 6;

endpackage

// File: rtl/tsg_rst_sync.sv
module tsg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tsg_phase.sv
module tsg_phase #(
  parameter int unsigned CNT_W = 4,
  localparam int unsigned EW = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  logic          clamp_req_i,
  output logic [EW-1:0] edge_o,
  output logic          armed_o,
  output logic          clamp_pend_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             clreq_q, clreq_d;

  // Index of the edge about to happen, counted from the last sync edge.
  // It is kept wide enough that a saturated count never matches a position.
  assign edge_o       = {1'b0, cnt_q} + EW'(1);
  assign armed_o      = armed_q;
  assign clamp_pend_o = clreq_q;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    clreq_d = clreq_q;
    if (sync_i) begin
      cnt_d   = '0;           // R10: restart on every sync
      armed_d = 1'b1;
      clreq_d = clamp_req_i;  // R4: request taken on the sync edge
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_MAX;
      armed_q <= 1'b0;
      clreq_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      clreq_q <= clreq_d;
    end
  end

endmodule

// File: rtl/tsg_strobe_dec.sv
module tsg_strobe_dec
  import tsg_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  localparam int unsigned EW = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] edge_i,
  input  logic          armed_i,
  input  logic          clamp_pend_i,
  input  mode_e         mode_i,
  input  logic          cds_en_i,
  input  logic [1:0]    rs_pos_i,
  output logic          vs_o,
  output logic          rs_o,
  output logic          cl_o
);

  logic [EW-1:0] rs_prog, rs_cds, rs_at, cl_at;
  logic          cds_eff;
  logic          vs_d, rs_d, cl_d;
  logic          vs_q, rs_q, cl_q;

  always_comb begin
    cds_eff = cds_en_i && (mode_i != MD_MAX);                // R9
    rs_prog = EW'(RS_DEFAULT - 1) + EW'(rs_pos_i);           // R3
    unique case (mode_i)
      MD_FAST: begin                                         // R8
        rs_cds = EW'(FAST_RS);
        cl_at  = EW'(FAST_RS - CL_LEAD);
      end
      MD_MAX: begin
        rs_cds = EW'(VS_EDGE);
        cl_at  = EW'(VS_EDGE);
      end
      default: begin
        rs_cds = rs_prog;
        cl_at  = rs_prog - EW'(CL_LEAD);
      end
    endcase
    rs_at = cds_eff ? rs_cds : EW'(VS_EDGE);                 // R5
    vs_d  = armed_i && (edge_i == EW'(VS_EDGE));
    rs_d  = armed_i && (edge_i == rs_at);
    cl_d  = armed_i && clamp_pend_i && (edge_i == cl_at);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q <= 1'b0;
      rs_q <= 1'b0;
      cl_q <= 1'b0;
    end else begin
      vs_q <= vs_d;
      rs_q <= rs_d;
      cl_q <= cl_d;
    end
  end

  assign vs_o = vs_q;
  assign rs_o = rs_q;
  assign cl_o = cl_q;

endmodule

// File: rtl/tsg_chan_seq.sv
module tsg_chan_seq
  import tsg_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned N_CH  = 3,
  localparam int unsigned EW   = CNT_W + 1,
  localparam int unsigned SEL_W = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EW-1:0]    edge_i,
  input  logic             armed_i,
  input  mode_e            mode_i,
  input  logic [SEL_W-1:0] mono_sel_i,
  output logic [N_CH-1:0]  mux_sel_o,
  output logic [SEL_W:0]   cc_o
);

  logic [EW-1:0]    step;
  logic [SEL_W-1:0] ch_idx;
  logic             rd_bit;
  logic             upd;
  logic [N_CH-1:0]  mux_d, mux_q;
  logic [SEL_W:0]   cc_d, cc_q;

  always_comb begin
    step = edge_i - EW'(1);
    upd  = armed_i && (edge_i >= EW'(1)) && (edge_i <= EW'(SEQ_LEN));
    if (mode_i == MD_COLOUR) begin
      ch_idx = SEL_W'(step >> 1);                            // R6
    end else if (32'(mono_sel_i) >= N_CH) begin
      ch_idx = '0;                                           // R7: reserved -> red
    end else begin
      ch_idx = mono_sel_i;
    end
    rd_bit = (mode_i == MD_COLOUR || mode_i == MD_MONO) ? step[0] : 1'b0;
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_onehot
    assign mux_d[g] = upd ? (32'(ch_idx) == g) : mux_q[g];
  end

  assign cc_d = upd ? {ch_idx, rd_bit} : cc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_q <= '0;
      cc_q  <= '0;
    end else begin
      mux_q <= mux_d;
      cc_q  <= cc_d;
    end
  end

  assign mux_sel_o = mux_q;
  assign cc_o      = cc_q;

endmodule

// File: rtl/tsg_timing_gen.sv
module tsg_timing_gen
  import tsg_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_i,
  input  logic       clamp_req_i,
  input  logic [1:0] mode_i,
  input  logic       cds_en_i,
  input  logic [1:0] rs_pos_i,
  input  logic [1:0] mono_sel_i,
  output logic       vs_strb_o,
  output logic       rs_strb_o,
  output logic       clamp_o,
  output logic [2:0] mux_sel_o,
  output logic [2:0] cc_o
);

  localparam int unsigned EW = CNT_W + 1;

  logic          rst_int_n;
  logic [EW-1:0] edge_idx;
  logic          armed;
  logic          clamp_pend;
  mode_e         mode;

  assign mode = mode_e'(mode_i);

  tsg_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  tsg_phase #(.CNT_W(CNT_W)) u_phase (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sync_i       (sync_i),
    .clamp_req_i  (clamp_req_i),
    .edge_o       (edge_idx),
    .armed_o      (armed),
    .clamp_pend_o (clamp_pend)
  );

  tsg_strobe_dec #(.CNT_W(CNT_W)) u_dec (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .edge_i       (edge_idx),
    .armed_i      (armed),
    .clamp_pend_i (clamp_pend),
    .mode_i       (mode),
    .cds_en_i     (cds_en_i),
    .rs_pos_i     (rs_pos_i),
    .vs_o         (vs_strb_o),
    .rs_o         (rs_strb_o),
    .cl_o         (clamp_o)
  );

  tsg_chan_seq #(.CNT_W(CNT_W), .N_CH(3)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .edge_i     (edge_idx),
    .armed_i    (armed),
    .mode_i     (mode),
    .mono_sel_i (mono_sel_i),
    .mux_sel_o  (mux_sel_o),
    .cc_o       (cc_o)
  );

endmodule

// File: rtl/tsg_timing_chk.sv
module tsg_timing_chk (
  input logic       clk,
  input logic       rst_int_n,
  input logic       armed,
  input logic [1:0] mode_i,
  input logic       cds_en_i,
  input logic       vs_strb_o,
  input logic       rs_strb_o,
  input logic       clamp_o,
  input logic [2:0] mux_sel_o
);

  p_idle_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !armed |-> (!vs_strb_o && !rs_strb_o && !clamp_o && mux_sel_o == 3'b000));

  p_mux_onehot_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(mux_sel_o));

  p_se_together_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((!cds_en_i || mode_i == 2'b11) && vs_strb_o) |-> rs_strb_o);

  p_max_no_cds_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_i == 2'b11 && rs_strb_o) |-> vs_strb_o);

  p_fast_fixed_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_i == 2'b10 && cds_en_i && rs_strb_o) |-> $past(vs_strb_o));

  p_clamp_lead_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clamp_o && cds_en_i && !mode_i[1]) |=> rs_strb_o);

endmodule

bind tsg_timing_gen tsg_timing_chk u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .armed     (armed),
  .mode_i    (mode_i),
  .cds_en_i  (cds_en_i),
  .vs_strb_o (vs_strb_o),
  .rs_strb_o (rs_strb_o),
  .clamp_o   (clamp_o),
  .mux_sel_o (mux_sel_o)
);

// File: tb/tb_tsg_timing_gen.sv
module tb_tsg_timing_gen;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_i, clamp_req_i, cds_en_i;
  logic [1:0] mode_i, rs_pos_i, mono_sel_i;
  logic       vs_strb_o, rs_strb_o, clamp_o;
  logic [2:0] mux_sel_o, cc_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] vs_tr, rs_tr, cl_tr;
  logic [2:0]  cc_tr  [1:14];
  logic [2:0]  mux_tr [1:14];

  always #(CLK_PERIOD/2) clk = ~clk;

  tsg_timing_gen dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_i      (sync_i),
    .clamp_req_i (clamp_req_i),
    .mode_i      (mode_i),
    .cds_en_i    (cds_en_i),
    .rs_pos_i    (rs_pos_i),
    .mono_sel_i  (mono_sel_i),
    .vs_strb_o   (vs_strb_o),
    .rs_strb_o   (rs_strb_o),
    .clamp_o     (clamp_o),
    .mux_sel_o   (mux_sel_o),
    .cc_o        (cc_o)
  );

  function automatic logic [15:0] at(input int e);
    logic [15:0] v;
    v = '0;
    if (e > 0) v[e] = 1'b1;
    return v;
  endfunction

  task automatic chk_edges(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act[14:1] !== exp[14:1]) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act[14:1], exp[14:1]);
    end
  endtask

  task automatic chk_val(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] md, input logic cds, input logic [1:0] pos,
                         input logic [1:0] sel);
    @(negedge clk);
    mode_i = md; cds_en_i = cds; rs_pos_i = pos; mono_sel_i = sel;
  endtask

  // Pulse sync (sampled on edge 0), record edges 1..14; resync>0 adds a sync on that edge
  task automatic run_seq(input logic req, input int resync);
    vs_tr = '0; rs_tr = '0; cl_tr = '0;
    @(negedge clk);
    sync_i = 1'b1; clamp_req_i = req;
    @(negedge clk);
    sync_i = 1'b0; clamp_req_i = 1'b0;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      vs_tr[k] = vs_strb_o; rs_tr[k] = rs_strb_o; cl_tr[k] = clamp_o;
      cc_tr[k] = cc_o; mux_tr[k] = mux_sel_o;
      sync_i = (resync > 0 && k == resync - 1);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk_val("R1 strobes in reset", {vs_strb_o, rs_strb_o, clamp_o}, 3'b000);
    chk_val("R1 mux in reset", mux_sel_o, 3'b000);
    @(negedge clk); rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk_val("R1 strobes before sync", {vs_strb_o, rs_strb_o, clamp_o}, 3'b000);
    chk_val("R1 cc before sync", cc_o, 3'b000);
  endtask

  task automatic t_colour_default;
    set_cfg(2'b00, 1'b1, 2'b01, 2'b00);
    run_seq(1'b1, 0);
    chk_edges("R2 video edge", vs_tr, at(1));
    chk_edges("R2 reset edge default", rs_tr, at(4));
    chk_edges("R4 clamp edge 3", cl_tr, at(3));
    for (int k = 1; k <= 6; k++) begin
      chk_val("R6 colour code", cc_tr[k], {2'((k - 1) / 2), 1'((k - 1) % 2)});
      chk_val("R6 mux select", mux_tr[k], 3'(1 << ((k - 1) / 2)));
    end
  endtask

  task automatic t_rs_pos;
    for (int p = 0; p < 4; p++) begin
      set_cfg(2'b00, 1'b1, 2'(p), 2'b00);
      run_seq(1'b1, 0);
      chk_edges("R3 reset position", rs_tr, at(3 + p));
      chk_edges("R3 clamp follows reset", cl_tr, at(2 + p));
      chk_edges("R11 single video pulse", vs_tr, at(1));
    end
  endtask

  task automatic t_no_clamp;
    set_cfg(2'b00, 1'b1, 2'b01, 2'b00);
    run_seq(1'b0, 0);
    chk_edges("R4 no clamp without request", cl_tr, at(0));
    chk_edges("R4 reset still fires", rs_tr, at(4));
  endtask

  task automatic t_single_ended;
    set_cfg(2'b00, 1'b0, 2'b10, 2'b00);
    run_seq(1'b1, 0);
    chk_edges("R5 reset with video", rs_tr, at(1));
    chk_edges("R5 clamp keeps position", cl_tr, at(4));
  endtask

  task automatic t_mono;
    set_cfg(2'b01, 1'b1, 2'b01, 2'b01);
    run_seq(1'b0, 0);
    for (int k = 1; k <= 6; k++) begin
      chk_val("R7 mono green code", cc_tr[k], {2'b01, 1'((k - 1) % 2)});
      chk_val("R7 mono green mux", mux_tr[k], 3'b010);
    end
    chk_edges("R7 mono reset default", rs_tr, at(4));
    set_cfg(2'b01, 1'b1, 2'b01, 2'b11);
    run_seq(1'b0, 0);
    chk_val("R7 reserved select code", cc_tr[2], 3'b001);
    chk_val("R7 reserved select mux", mux_tr[3], 3'b001);
  endtask

  task automatic t_fast;
    set_cfg(2'b10, 1'b1, 2'b11, 2'b10);
    run_seq(1'b1, 0);
    chk_edges("R8 fast reset fixed", rs_tr, at(2));
    chk_edges("R8 fast clamp fixed", cl_tr, at(1));
    chk_edges("R8 fast video", vs_tr, at(1));
    chk_val("R8 fast code", cc_tr[2], 3'b100);
    chk_val("R8 fast mux", mux_tr[1], 3'b100);
  endtask

  task automatic t_max;
    set_cfg(2'b11, 1'b1, 2'b11, 2'b00);
    run_seq(1'b1, 0);
    chk_edges("R9 max reset with video", rs_tr, at(1));
    chk_edges("R9 max clamp", cl_tr, at(1));
    chk_val("R9 max code", cc_tr[2], 3'b000);
  endtask

  task automatic t_resync;
    set_cfg(2'b00, 1'b1, 2'b01, 2'b00);
    run_seq(1'b0, 3);
    chk_edges("R10 video from both syncs", vs_tr, at(1) | at(4));
    chk_edges("R10 stale reset dropped", rs_tr, at(7));
    chk_val("R10 code after restart", cc_tr[4], 3'b000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync_i = 1'b0; clamp_req_i = 1'b0;
    mode_i = 2'b00; cds_en_i = 1'b1; rs_pos_i = 2'b01; mono_sel_i = 2'b00;
    repeat (3) @(negedge clk);
    t_reset();
    t_colour_default();
    t_rs_pos();
    t_no_clamp();
    t_single_ended();
    t_mono();
    t_fast();
    t_max();
    t_resync();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule